// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a bus-attached watchdog peripheral. A down-counter, clocked by the block clock, counts from a programmed load value toward zero while the timer is enabled. The first time it runs out, the block raises an interrupt. If software has not cleared that interrupt before the counter runs out a second time, and the reset enable is set, the block raises a system reset request. The reset request then stays high until the block itself is reset.

Software works the block through a small register set on a simple APB-style bus. Every access completes in one cycle, and no access signals an error. A lock register guards all other registers. Writing the unlock key opens them, and writing any other value closes them again. While the block is locked, reads still work, but writes to any register other than the lock register have no effect. Writing the interrupt-clear register, or writing the control register with the enable bit set, reloads the counter. Software services the watchdog through either of these writes.

Top module: `wdg_twostage`

## Requirements
- R1: After reset the block is unlocked, the load register and the count both read 0xFFFFFFFF, control reads 0, raw and masked status read 0, and both `irq` and `sys_rst_req` are low.
- R2: Register offsets are: load 0x000 (read/write), count 0x004 (read-only), control 0x008, interrupt clear 0x00C (write-only), raw status 0x010, masked status 0x014, and lock 0xC00. Writing 0x1ACCE551 to the lock register unlocks the block. Writing any other value locks it. The lock register reads 1 in bit 0 while the block is locked.
- R3: While the block is locked, writes to load, control and interrupt clear change nothing. Reads still return the current values.
- R4: Control bit 0 is the run enable, which also enables the interrupt. Control bit 1 is the reset enable. Bits 31:2 read as zero, whatever was written to them.
- R5: While run enable is 1, the count drops by one each clock cycle. While run enable is 0, the count holds.
- R6: In the cycle after the count is zero with run enable set, the count takes the load value and the raw status (bit 0) becomes 1. A load of L therefore raises the interrupt L+1 cycles after the reloading write.
- R7: When the count expires while the raw status is already 1 and the reset enable is set, `sys_rst_req` rises, 2L+2 cycles after a reload with load L. It then stays high until block reset.
- R8: With the reset enable clear, repeated expiries never raise `sys_rst_req`.
- R9: Any unlocked write to interrupt clear sets the raw status to 0 and loads the count from the load register.
- R10: An unlocked control write with bit 0 set loads the count from the load register, even if run enable is already 1.
- R11: The masked status and `irq` equal the raw status ANDed with run enable.
- R12: Reads from unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for a write |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational, zero when psel is low |
| irq | output | 1 | Interrupt: raw status masked by run enable |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
A wrong count shows on the count register in the very next read. It also moves the `irq` edge away from the L+1 cycle point, so the bench samples `irq` exactly one cycle before and one cycle after that point. A raw status bit that is stuck or not cleared shows up later. It makes `sys_rst_req` rise early, late or never at the 2L+2 point, or it leaves the masked status out of step with the raw status once the enable changes. A lock state that fails to take shows at the ports as a load value or count that moved while it should have held.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_LOAD  = 12'h000;
  localparam logic [BUS_AW-1:0] OFS_COUNT = 12'h004;
  localparam logic [BUS_AW-1:0] OFS_CTRL  = 12'h008;
  localparam logic [BUS_AW-1:0] OFS_ICLR  = 12'h00C;
  localparam logic [BUS_AW-1:0] OFS_RAW   = 12'h010;
  localparam logic [BUS_AW-1:0] OFS_MASK  = 12'h014;
  localparam logic [BUS_AW-1:0] OFS_LOCK  = 12'hC00;

  localparam logic [BUS_DW-1:0] UNLOCK_KEY = 32'h1ACCE551;

  // Control field layout: bit 1 reset enable, bit 0 run enable.
  typedef struct packed {
    logic rst_en;
    logic run_en;
  } wdg_ctrl_t;
endpackage

// File: rtl/wdg_lock.sv
module wdg_lock
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_we,
  input  logic [BUS_DW-1:0] wdata,
  output logic              locked
);
  logic locked_q, locked_d;

  always_comb begin
    locked_d = locked_q;
    if (lock_we) locked_d = (wdata != UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else        locked_q <= locked_d;
  end

  assign locked = locked_q;
endmodule

// File: rtl/wdg_cfg.sv
module wdg_cfg
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_we,
  input  logic              ctrl_we,
  input  logic [BUS_DW-1:0] wdata,
  output logic [CNT_W-1:0]  load_val,
  output wdg_ctrl_t         ctrl
);
  logic [CNT_W-1:0] load_q, load_d;
  wdg_ctrl_t        ctrl_q, ctrl_d;

  always_comb begin
    load_d = load_q;
    ctrl_d = ctrl_q;
    if (load_we) load_d = wdata[CNT_W-1:0];
    if (ctrl_we) ctrl_d = wdg_ctrl_t'(wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '1;
      ctrl_q <= '0;
    end else begin
      load_q <= load_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign load_val = load_q;
  assign ctrl     = ctrl_q;
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             rst_en,
  input  logic             reload,
  input  logic             clr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             raw_pend,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             raw_q, raw_d;
  logic             rst_q, rst_d;
  logic             expire;

  // A reload in the same cycle takes the place of the expiry.
  assign expire = run_en && (cnt_q == '0) && !reload;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)      cnt_d = load_val;
    else if (run_en) cnt_d = (cnt_q == '0) ? load_val : cnt_q - CNT_W'(1);

    raw_d = raw_q;
    if (clr)         raw_d = 1'b0;
    else if (expire) raw_d = 1'b1;

    rst_d = rst_q | (expire & raw_q & rst_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      raw_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      raw_q <= raw_d;
      rst_q <= rst_d;
    end
  end

  assign count    = cnt_q;
  assign raw_pend = raw_q;
  assign rst_req  = rst_q;
endmodule

// File: rtl/wdg_twostage.sv
module wdg_twostage
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [BUS_AW-1:0] paddr,
  input  logic [BUS_DW-1:0] pwdata,
  output logic [BUS_DW-1:0] prdata,
  output logic              irq,
  output logic              sys_rst_req
);
  logic             bus_wr, open_wr;
  logic             locked;
  logic [CNT_W-1:0] load_q, cnt_q;
  wdg_ctrl_t        ctrl_q;
  logic             run_en, rst_en, raw_q, masked;
  logic             we_load, we_ctrl, we_iclr, reload;

  assign bus_wr  = psel && penable && pwrite;
  assign open_wr = bus_wr && !locked;
  assign we_load = open_wr && (paddr == OFS_LOAD);
  assign we_ctrl = open_wr && (paddr == OFS_CTRL);
  assign we_iclr = open_wr && (paddr == OFS_ICLR);
  assign reload  = we_iclr || (we_ctrl && pwdata[0]);

  wdg_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_we (bus_wr && (paddr == OFS_LOCK)),
    .wdata   (pwdata),
    .locked  (locked)
  );

  wdg_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_we  (we_load),
    .ctrl_we  (we_ctrl),
    .wdata    (pwdata),
    .load_val (load_q),
    .ctrl     (ctrl_q)
  );

  assign run_en = ctrl_q.run_en;
  assign rst_en = ctrl_q.rst_en;

  wdg_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .rst_en   (rst_en),
    .reload   (reload),
    .clr      (we_iclr),
    .load_val (load_q),
    .count    (cnt_q),
    .raw_pend (raw_q),
    .rst_req  (sys_rst_req)
  );

  assign masked = raw_q & run_en;
  assign irq    = masked;

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (paddr)
        OFS_LOAD:  prdata = BUS_DW'(load_q);
        OFS_COUNT: prdata = BUS_DW'(cnt_q);
        OFS_CTRL:  prdata = BUS_DW'(ctrl_q);
        OFS_RAW:   prdata = BUS_DW'(raw_q);
        OFS_MASK:  prdata = BUS_DW'(masked);
        OFS_LOCK:  prdata = BUS_DW'(locked);
        default:   prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [BUS_AW-1:0] paddr,
  input logic              locked,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              raw_q,
  input logic              run_en,
  input logic              rst_en,
  input logic              sys_rst_req
);
  logic any_wr;
  assign any_wr = psel && penable && pwrite;

  assert_locked_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked && any_wr && (paddr == OFS_LOAD) |=> $stable(load_q));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && (cnt_q != '0) && !any_wr |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !any_wr |=> $stable(cnt_q));

  assert_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && (cnt_q == '0) && !any_wr |=> raw_q && (cnt_q == $past(load_q)));

  assert_sticky_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);

  assert_no_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_en && !sys_rst_req |=> !sys_rst_req);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && any_wr && (paddr == OFS_ICLR) |=> !raw_q && (cnt_q == $past(load_q)));
endmodule

bind wdg_twostage wdg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .locked      (locked),
  .load_q      (load_q),
  .cnt_q       (cnt_q),
  .raw_q       (raw_q),
  .run_en      (run_en),
  .rst_en      (rst_en),
  .sys_rst_req (sys_rst_req)
);

// File: tb/test_wdg_twostage.sv
`timescale 1ns/1ps
module test_wdg_twostage;
  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_ICLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014,
                          A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;
  localparam int L = 10;

  // Each vector: offset, write data, expected read-back from the same offset.
  localparam int NV = 8;
  localparam logic [75:0] VEC [NV] = '{
    {A_LOAD, 32'h12345678, 32'h12345678},
    {A_LOAD, 32'h00000007, 32'h00000007},
    {A_CTRL, 32'hFFFFFFFE, 32'h00000002},
    {A_CTRL, 32'h00000000, 32'h00000000},
    {12'h020, 32'hFFFFFFFF, 32'h00000000},
    {12'h018, 32'h0000AAAA, 32'h00000000},
    {A_LOCK, 32'hDEADBEEF, 32'h00000001},
    {A_LOCK, KEY,          32'h00000000}
  };

  logic clk = 1'b0, rst_n, psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic irq, sys_rst_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] rd, rd2;

  always #2.5 clk = ~clk;

  wdg_twostage i_wdg_twostage (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
    .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write takes effect at the second rising edge.
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  // Samples the read data in the setup phase, at the falling edge it starts on.
  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    #1 d = prdata;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_LOCK, rd); chk("R1 lock", rd, 0);
    bus_rd(A_LOAD, rd); chk("R1 load", rd, 32'hFFFFFFFF);
    bus_rd(A_CNT,  rd); chk("R1 count", rd, 32'hFFFFFFFF);
    bus_rd(A_CTRL, rd); chk("R1 ctrl", rd, 0);
    bus_rd(A_RAW,  rd); chk("R1 raw", rd, 0);
    bus_rd(A_MASK, rd); chk("R1 masked", rd, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rst", {31'b0, sys_rst_req}, 0);

    // Vector table: R2 lock encoding, R4 reserved bits, R12 unmapped reads
    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i][75:64], VEC[i][63:32]);
      bus_rd(VEC[i][75:64], rd);
      chk($sformatf("R2 R4 R12 vector %0d", i), rd, VEC[i][31:0]);
    end

    // R3 locked writes ignored
    bus_wr(A_LOCK, 32'h0);
    bus_rd(A_LOCK, rd); chk("R2 locked bit", rd, 1);
    bus_wr(A_LOAD, 32'h55);
    bus_wr(A_CTRL, 32'h3);
    bus_wr(A_ICLR, 32'h1);
    bus_rd(A_LOAD, rd); chk("R3 load kept", rd, 7);
    bus_rd(A_CTRL, rd); chk("R3 ctrl kept", rd, 0);
    bus_rd(A_CNT,  rd); chk("R3 count kept", rd, 32'hFFFFFFFF);
    bus_wr(A_LOCK, KEY);

    // R5 count down and hold
    bus_wr(A_LOAD, 100);
    bus_wr(A_CTRL, 1);
    bus_rd(A_CNT, rd); chk("R5 count at reload", rd, 100);
    bus_rd(A_CNT, rd); chk("R5 count after 2", rd, 98);
    bus_wr(A_CTRL, 0);
    bus_rd(A_CNT, rd);
    bus_rd(A_CNT, rd2); chk("R5 hold while off", rd2, rd);

    // R6 first expiry, R11 masking
    bus_wr(A_LOAD, L);
    bus_wr(A_CTRL, 1);
    repeat (L) @(negedge clk);
    chk("R6 irq before expiry", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R6 irq at expiry", {31'b0, irq}, 1);
    bus_rd(A_CNT, rd);  chk("R6 reloaded count", rd, L);
    bus_rd(A_RAW, rd);  chk("R6 raw set", rd, 1);
    bus_rd(A_MASK, rd); chk("R11 masked set", rd, 1);
    bus_wr(A_CTRL, 0);
    bus_rd(A_MASK, rd); chk("R11 masked off", rd, 0);
    bus_rd(A_RAW, rd);  chk("R11 raw kept", rd, 1);
    chk("R11 irq off", {31'b0, irq}, 0);

    // R8 no reset when reset enable clear
    bus_wr(A_CTRL, 1);
    repeat (3 * L + 6) @(negedge clk);
    chk("R8 no reset", {31'b0, sys_rst_req}, 0);
    chk("R8 irq pending", {31'b0, irq}, 1);

    // R9 clear reloads and clears
    bus_wr(A_ICLR, 32'hABCD);
    bus_rd(A_CNT, rd); chk("R9 count reloaded", rd, L);
    bus_rd(A_RAW, rd); chk("R9 raw cleared", rd, 0);

    // R10 rewrite of enable reloads
    repeat (4) @(negedge clk);
    bus_wr(A_CTRL, 1);
    bus_rd(A_CNT, rd); chk("R10 count reloaded", rd, L);

    // R7 second expiry raises sticky reset
    bus_wr(A_ICLR, 1);
    bus_wr(A_CTRL, 3);
    repeat (2 * L + 1) @(negedge clk);
    chk("R7 no reset yet", {31'b0, sys_rst_req}, 0);
    chk("R7 irq pending", {31'b0, irq}, 1);
    @(negedge clk);
    chk("R7 reset raised", {31'b0, sys_rst_req}, 1);
    bus_wr(A_CTRL, 0);
    bus_wr(A_ICLR, 1);
    repeat (5) @(negedge clk);
    chk("R7 reset sticky", {31'b0, sys_rst_req}, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule